// File: doc/BRIEF.md
# Hysteretic Digital Lock Detector

This block watches the reference and feedback clocks that enter a phase-frequency detector and reports whether the loop is locked. Both inputs are already synchronous to a fast sampling clock. The block finds their rising edges and measures the skew between them as a count of sample-clock cycles. Each measurement is then sorted into one of three classes: good (inside the lock window), neutral (between the lock and unlock windows) or bad (beyond the unlock window, or timed out).

The lock flag rises only after a programmable run of consecutive good measurements. Once it is up, only a single bad measurement clears it, so phase error in the neutral band does not make the flag chatter. A second output, the qualified lock, rises only after the lock flag has been continuously high for a programmable number of sample cycles. It falls in the same cycle as the lock flag, and its timing restarts from zero the next time lock is gained.

The window size comes from a window-select bit and a 2-bit pulse-width setting. The run length comes from a 2-bit field, and the qualification interval comes from a 16-bit value. For correct operation the PFD period must be longer than the unlock window.

Top module: `ld_lock_detect`

## Requirements
- R1: While reset (rst_n low) is asserted, lock_o and qual_lock_o are 0, and all counters restart from zero.
- R2: Skew is the number of sample-clock edges between the first rising edge and the rising edge of the other input, measured in either order. Edges seen on the same clock give a skew of 0.
- R3: The lock threshold is 2*(abl_sel_i+1) cycles, doubled when win_sel_i is 1 (values 2..16). The unlock threshold is twice the lock threshold. A measurement is good when skew < lock threshold, and bad when skew > unlock threshold or the measurement timed out.
- R4: While unlocked, lock_o rises after a run of consecutive good measurements whose length is set by run_sel_i: 0 gives 5, 1 gives 16, 2 gives 64 and 3 gives 255.
- R5: While unlocked, any measurement that is not good (skew >= lock threshold) resets the run to zero.
- R6: While locked, one bad measurement clears lock_o. Measurements with skew <= unlock threshold leave lock_o set.
- R7: A measurement is treated as timed out, and therefore bad, in two cases: the second edge has not arrived within TIMEOUT sample cycles of the first, or the first input rises again before the other input has risen.
- R8: qual_lock_o rises at the (qual_len_i+1)-th consecutive clock edge at which lock_o is high. It is never high while lock_o is low, and after a loss of lock it times a full interval again.
- R9: lock_o changes only in the cycle after a measurement completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Sampled reference clock |
| fb_i | input | 1 | Sampled feedback clock |
| win_sel_i | input | 1 | Window select; 1 doubles both thresholds |
| abl_sel_i | input | 2 | Pulse-width setting that scales the thresholds |
| run_sel_i | input | 2 | Selects consecutive good cycles needed for lock |
| qual_len_i | input | 16 | Qualification interval in sample cycles |
| lock_o | output | 1 | Hysteretic lock flag |
| qual_lock_o | output | 1 | Qualified lock flag |

## Verification
On every cycle, the assertions check the following:
- the qualified flag never stands without the lock flag;
- a bad measurement always drops an existing lock;
- lock moves only after a completed measurement;
- lock rises only on a good measurement;
- a non-good measurement clears the run while unlocked;
- the pending-edge counter stays within its timeout.

Only the bench's scenarios can show that the exact boundary skews fall on the stated side of each window, that each run-length code needs exactly its count, and that the timeout breaks lock. The same holds for edge ordering and for the length and restart of the qualification interval.

// File: rtl/ld_pkg.sv
package ld_pkg;

  localparam int THR_W = 6;
  localparam int RUN_W = 8;

  typedef enum logic [1:0] {
    SK_IDLE = 2'd0,
    SK_REF  = 2'd1,
    SK_FB   = 2'd2
  } sk_state_e;

  // lock window: 2*(abl+1), doubled by the window-select bit
  function automatic logic [THR_W-1:0] lock_thr_f(input logic win, input logic [1:0] abl);
    logic [THR_W-1:0] base;
    base = THR_W'(abl) + THR_W'(1);
    return win ? (base << 2) : (base << 1);
  endfunction

  // unlock window is twice the lock window
  function automatic logic [THR_W-1:0] unlock_thr_f(input logic win, input logic [1:0] abl);
    return lock_thr_f(win, abl) << 1;
  endfunction

  // consecutive good cycles needed to declare lock
  function automatic logic [RUN_W-1:0] run_len_f(input logic [1:0] sel);
    case (sel)
      2'd0:    return RUN_W'(5);
      2'd1:    return RUN_W'(16);
      2'd2:    return RUN_W'(64);
      default: return RUN_W'(255);
    endcase
  endfunction

endpackage

// File: rtl/ld_edge_skew.sv
module ld_edge_skew
  import ld_pkg::*;
#(
  parameter int TIMEOUT = 64,
  parameter int SKW_W   = $clog2(TIMEOUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_i,
  input  logic             fb_i,
  output logic             meas_vld_o,
  output logic [SKW_W-1:0] meas_skew_o,
  output logic             meas_tmo_o,
  output logic [SKW_W-1:0] pend_cnt_o
);

  logic             ref_q, fb_q;
  logic             ref_rise, fb_rise;
  logic             first_rise, second_rise;
  logic             at_limit;
  sk_state_e        st;
  logic [SKW_W-1:0] cnt;

  assign ref_rise    = ref_i & ~ref_q;
  assign fb_rise     = fb_i & ~fb_q;
  // in a pending state, "first" is the input that opened the measurement
  assign first_rise  = (st == SK_REF) ? ref_rise : fb_rise;
  assign second_rise = (st == SK_REF) ? fb_rise : ref_rise;
  assign at_limit    = (cnt == SKW_W'(TIMEOUT));
  assign pend_cnt_o  = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q       <= 1'b0;
      fb_q        <= 1'b0;
      st          <= SK_IDLE;
      cnt         <= '0;
      meas_vld_o  <= 1'b0;
      meas_skew_o <= '0;
      meas_tmo_o  <= 1'b0;
    end else begin
      ref_q      <= ref_i;
      fb_q       <= fb_i;
      meas_vld_o <= 1'b0;
      meas_tmo_o <= 1'b0;
      if (st == SK_IDLE) begin
        if (ref_rise && fb_rise) begin
          meas_vld_o  <= 1'b1;
          meas_skew_o <= '0;
        end else if (ref_rise) begin
          st  <= SK_REF;
          cnt <= SKW_W'(1);
        end else if (fb_rise) begin
          st  <= SK_FB;
          cnt <= SKW_W'(1);
        end
      end else begin
        if (second_rise) begin
          meas_vld_o  <= 1'b1;
          meas_skew_o <= cnt;
          st          <= SK_IDLE;
          cnt         <= '0;
        end else if (first_rise || at_limit) begin
          meas_vld_o  <= 1'b1;
          meas_tmo_o  <= 1'b1;
          meas_skew_o <= cnt;
          if (first_rise) begin
            cnt <= SKW_W'(1);
          end else begin
            st  <= SK_IDLE;
            cnt <= '0;
          end
        end else begin
          cnt <= cnt + SKW_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/ld_classify.sv
module ld_classify
  import ld_pkg::*;
#(
  parameter int SKW_W = 7
) (
  input  logic             meas_vld_i,
  input  logic [SKW_W-1:0] meas_skew_i,
  input  logic             meas_tmo_i,
  input  logic             win_sel_i,
  input  logic [1:0]       abl_sel_i,
  output logic             good_o,
  output logic             bad_o
);

  localparam int CMP_W = ((SKW_W > THR_W) ? SKW_W : THR_W) + 1;

  logic [CMP_W-1:0] skew_x, lock_x, unlock_x;

  assign skew_x   = CMP_W'(meas_skew_i);
  assign lock_x   = CMP_W'(lock_thr_f(win_sel_i, abl_sel_i));
  assign unlock_x = CMP_W'(unlock_thr_f(win_sel_i, abl_sel_i));

  assign good_o = meas_vld_i && !meas_tmo_i && (skew_x < lock_x);
  assign bad_o  = meas_vld_i && (meas_tmo_i || (skew_x > unlock_x));

endmodule

// File: rtl/ld_run_lock.sv
module ld_run_lock
  import ld_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_vld_i,
  input  logic             good_i,
  input  logic             bad_i,
  input  logic [1:0]       run_sel_i,
  output logic             lock_o,
  output logic [RUN_W-1:0] run_cnt_o
);

  logic [RUN_W:0] run_nxt;
  logic [RUN_W:0] target;

  assign run_nxt = {1'b0, run_cnt_o} + (RUN_W+1)'(1);
  assign target  = {1'b0, run_len_f(run_sel_i)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_o    <= 1'b0;
      run_cnt_o <= '0;
    end else if (meas_vld_i) begin
      if (lock_o) begin
        if (bad_i) begin
          lock_o <= 1'b0;
        end
        run_cnt_o <= '0;
      end else if (good_i) begin
        if (run_nxt >= target) begin
          lock_o    <= 1'b1;
          run_cnt_o <= '0;
        end else begin
          run_cnt_o <= run_nxt[RUN_W-1:0];
        end
      end else begin
        run_cnt_o <= '0;
      end
    end
  end

endmodule

// File: rtl/ld_qual_timer.sv
module ld_qual_timer #(
  parameter int QUAL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic [QUAL_W-1:0] qual_len_i,
  output logic              qual_o
);

  logic [QUAL_W-1:0] tmr;
  logic              q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0;
      q   <= 1'b0;
    end else if (!lock_i) begin
      tmr <= '0;
      q   <= 1'b0;
    end else if (tmr == qual_len_i) begin
      q <= 1'b1;
    end else begin
      tmr <= tmr + QUAL_W'(1);
    end
  end

  // gated by the live lock flag so a loss clears the output at once
  assign qual_o = q & lock_i;

endmodule

// File: rtl/ld_lock_detect.sv
module ld_lock_detect
  import ld_pkg::*;
#(
  parameter int TIMEOUT = 64,
  parameter int QUAL_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_i,
  input  logic              fb_i,
  input  logic              win_sel_i,
  input  logic [1:0]        abl_sel_i,
  input  logic [1:0]        run_sel_i,
  input  logic [QUAL_W-1:0] qual_len_i,
  output logic              lock_o,
  output logic              qual_lock_o
);

  localparam int SKW_W = $clog2(TIMEOUT + 1);

  logic             meas_vld;
  logic [SKW_W-1:0] meas_skew;
  logic             meas_tmo;
  logic [SKW_W-1:0] pend_cnt;
  logic             meas_good;
  logic             meas_bad;
  logic [RUN_W-1:0] run_cnt;

  ld_edge_skew #(.TIMEOUT(TIMEOUT), .SKW_W(SKW_W)) u_skew (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_i      (ref_i),
    .fb_i       (fb_i),
    .meas_vld_o (meas_vld),
    .meas_skew_o(meas_skew),
    .meas_tmo_o (meas_tmo),
    .pend_cnt_o (pend_cnt)
  );

  ld_classify #(.SKW_W(SKW_W)) u_cls (
    .meas_vld_i (meas_vld),
    .meas_skew_i(meas_skew),
    .meas_tmo_i (meas_tmo),
    .win_sel_i  (win_sel_i),
    .abl_sel_i  (abl_sel_i),
    .good_o     (meas_good),
    .bad_o      (meas_bad)
  );

  ld_run_lock u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .meas_vld_i(meas_vld),
    .good_i    (meas_good),
    .bad_i     (meas_bad),
    .run_sel_i (run_sel_i),
    .lock_o    (lock_o),
    .run_cnt_o (run_cnt)
  );

  ld_qual_timer #(.QUAL_W(QUAL_W)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_i    (lock_o),
    .qual_len_i(qual_len_i),
    .qual_o    (qual_lock_o)
  );

endmodule

// File: rtl/ld_lock_detect_chk.sv
module ld_lock_detect_chk #(
  parameter int SKW_W   = 7,
  parameter int RUN_W   = 8,
  parameter int TIMEOUT = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lock_o,
  input logic             qual_lock_o,
  input logic             meas_vld,
  input logic             meas_good,
  input logic             meas_bad,
  input logic [RUN_W-1:0] run_cnt,
  input logic [SKW_W-1:0] pend_cnt
);

  // R8
  qual_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qual_lock_o |-> lock_o);

  // R8
  qual_rise_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual_lock_o) |-> $past(lock_o));

  // R6
  unlock_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && meas_bad) |=> !lock_o);

  // R9
  lock_moves_on_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_vld |=> $stable(lock_o));

  // R4
  lock_rise_on_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(meas_good));

  // R5
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_o && meas_vld && !meas_good) |=> (run_cnt == '0));

  // R7
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= SKW_W'(TIMEOUT));

endmodule

bind ld_lock_detect ld_lock_detect_chk #(
  .SKW_W  (SKW_W),
  .RUN_W  (ld_pkg::RUN_W),
  .TIMEOUT(TIMEOUT)
) u_chk (.*);

// File: tb/sim_ld_lock_detect.sv
`timescale 1ns/1ps
module sim_ld_lock_detect;

  localparam int FILL    = 44;
  localparam int TIMEOUT = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_r = 1'b0;
  logic        fb_r = 1'b0;
  logic        win = 1'b0;
  logic [1:0]  abl = 2'd0;
  logic [1:0]  run = 2'd0;
  logic [15:0] qlen = 16'd30;
  logic        lock_w, qual_w;

  int checks = 0;
  int failures = 0;
  int qual_orphan = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ld_lock_detect #(.TIMEOUT(TIMEOUT), .QUAL_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_r), .fb_i(fb_r),
    .win_sel_i(win), .abl_sel_i(abl), .run_sel_i(run),
    .qual_len_i(qlen), .lock_o(lock_w), .qual_lock_o(qual_w)
  );

  // R8: qualified flag must never be seen without lock
  always @(negedge clk) if (rst_n && qual_w && !lock_w) qual_orphan++;

  // row: win, abl, skew, fb_first, repeats, expected lock (qual expected equal)
  localparam logic [13:0] TBL [0:15] = '{
    {1'b0, 2'd0, 6'd1,  1'b0, 3'd4, 1'b0},  // R4 four good: not yet
    {1'b0, 2'd0, 6'd1,  1'b0, 3'd1, 1'b1},  // R4 fifth good: lock
    {1'b0, 2'd0, 6'd3,  1'b0, 3'd3, 1'b1},  // R6 neutral holds
    {1'b0, 2'd0, 6'd4,  1'b0, 3'd1, 1'b1},  // R6 at unlock thr holds
    {1'b0, 2'd0, 6'd5,  1'b0, 3'd1, 1'b0},  // R6 beyond unlock drops
    {1'b0, 2'd0, 6'd1,  1'b0, 3'd3, 1'b0},  // R5 partial run
    {1'b0, 2'd0, 6'd2,  1'b0, 3'd1, 1'b0},  // R5 skew==lock thr resets run
    {1'b0, 2'd0, 6'd1,  1'b0, 3'd4, 1'b0},  // R5 run restarted
    {1'b0, 2'd0, 6'd1,  1'b0, 3'd1, 1'b1},  // R5 relock
    {1'b1, 2'd0, 6'd5,  1'b0, 3'd1, 1'b1},  // R3 wide window neutral
    {1'b1, 2'd0, 6'd8,  1'b0, 3'd1, 1'b1},  // R3 wide unlock edge
    {1'b1, 2'd0, 6'd9,  1'b0, 3'd1, 1'b0},  // R3 wide beyond unlock
    {1'b1, 2'd3, 6'd15, 1'b0, 3'd5, 1'b1},  // R3 largest lock window
    {1'b1, 2'd3, 6'd0,  1'b0, 3'd1, 1'b1},  // R2 coincident edges
    {1'b0, 2'd3, 6'd17, 1'b1, 3'd1, 1'b0},  // R2 fb first, bad
    {1'b0, 2'd3, 6'd7,  1'b1, 3'd5, 1'b1}   // R2 fb first, good run
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_r = 1'b0; fb_r = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one PFD period; called and returns at a negedge
  task automatic pfd(input int d, input bit fbf);
    if (d == 0) begin
      ref_r = 1'b1; fb_r = 1'b1;
      @(negedge clk);
      ref_r = 1'b0; fb_r = 1'b0;
      repeat (FILL + 1) @(negedge clk);
    end else begin
      if (fbf) fb_r = 1'b1; else ref_r = 1'b1;
      @(negedge clk);
      ref_r = 1'b0; fb_r = 1'b0;
      repeat (d - 1) @(negedge clk);
      if (fbf) ref_r = 1'b1; else fb_r = 1'b1;
      @(negedge clk);
      ref_r = 1'b0; fb_r = 1'b0;
      repeat (FILL) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int tgt;
    do_reset();
    // R1 reset state
    chk("R1 lock after reset", lock_w, 1'b0);
    chk("R1 qual after reset", qual_w, 1'b0);

    // table walk: run 5, qual interval 30
    for (int i = 0; i < 16; i++) begin
      win = TBL[i][13];
      abl = TBL[i][12:11];
      for (int k = 0; k < int'(TBL[i][3:1]); k++) pfd(int'(TBL[i][10:5]), TBL[i][4]);
      chk($sformatf("R2/R3/R4/R5/R6 row %0d lock", i), lock_w, TBL[i][0]);
      chk($sformatf("R8 row %0d qual", i), qual_w, TBL[i][0]);
    end

    // R1: reset while locked clears both outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 lock in reset", lock_w, 1'b0);
    chk("R1 qual in reset", qual_w, 1'b0);

    // R4 each run length code
    win = 1'b0; abl = 2'd0;
    for (int s = 0; s < 4; s++) begin
      run = 2'(s);
      tgt = (s == 0) ? 5 : (s == 1) ? 16 : (s == 2) ? 64 : 255;
      do_reset();
      for (int k = 0; k < tgt - 1; k++) pfd(1, 1'b0);
      chk($sformatf("R4 sel %0d one short", s), lock_w, 1'b0);
      pfd(1, 1'b0);
      chk($sformatf("R4 sel %0d full run", s), lock_w, 1'b1);
    end

    // R7 timeout: reference edge with no feedback edge
    run = 2'd0;
    ref_r = 1'b1;
    @(negedge clk);
    ref_r = 1'b0;
    repeat (TIMEOUT + 20) @(negedge clk);
    chk("R7 timeout drops lock", lock_w, 1'b0);

    // R7 repeated first edge: relock, then two feedback edges with no reference
    for (int k = 0; k < 5; k++) pfd(1, 1'b0);
    chk("R7 relock", lock_w, 1'b1);
    fb_r = 1'b1; @(negedge clk); fb_r = 1'b0;
    repeat (20) @(negedge clk);
    fb_r = 1'b1; @(negedge clk); fb_r = 1'b0;
    repeat (10) @(negedge clk);
    chk("R7 repeated edge drops lock", lock_w, 1'b0);

    // R8 qualification interval and restart
    qlen = 16'd100;
    do_reset();
    for (int k = 0; k < 5; k++) pfd(1, 1'b0);
    chk("R8 lock up", lock_w, 1'b1);
    chk("R8 qual waits", qual_w, 1'b0);
    pfd(1, 1'b0);
    chk("R8 qual still waits", qual_w, 1'b0);
    pfd(1, 1'b0);
    chk("R8 qual after interval", qual_w, 1'b1);
    pfd(5, 1'b0);
    chk("R8 qual clears with lock", qual_w, 1'b0);
    for (int k = 0; k < 5; k++) pfd(1, 1'b0);
    chk("R8 qual restarts", qual_w, 1'b0);
    qlen = 16'd0;
    do_reset();
    for (int k = 0; k < 5; k++) pfd(1, 1'b0);
    chk("R8 zero interval", qual_w, 1'b1);

    checks++;
    if (qual_orphan != 0) begin
      failures++;
      $display("FAIL R8 qual without lock actual=%0d expected=0", qual_orphan);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule